// File: doc/BRIEF.md
# Parallel Bit-Plane Encoder for Single-Wire LED Strings

This block drives a bank of single-wire serial addressable LED strings side by side, one output line per string. Each frame carries a run-time number of LED positions; for every position the block fetches one 24-bit colour word per channel through a request strobe. It then serialises all channels together as bit-planes, so every output word carries the same bit of every channel at once.

Every LED data bit becomes three equal slots. The first slot drives every line high. The second slot drives each line with its own channel's bit. The third slot drives every line low. With a 400 ns slot this gives the usual long-high/short-low one and short-high/long-low zero. A frame opens and closes with four all-zero slots. Slot pacing comes from an internal prescaler derived from the clock frequency. The colour for the next position is fetched while the final bit of the current one is still being sent, so the slot stream never pauses.

Top module: `led_strand_encoder`

## Requirements
- R1: While reset is held and afterwards until the first start, `line_out`, `busy`, `done`, `slot_vld` and `col_req` are all zero.
- R2: A frame with N LED positions emits exactly 8 + 72·N slots. The first four and the last four are all-zero words.
- R3: Each data bit takes three slots in this order: all lines 1, then the data plane, then all lines 0.
- R4: Channel c takes its colour from `col_data[24c+23:24c]`, with red in bits 23:16, green in 15:8 and blue in 7:0. It is sent on `line_out[c]` as green, then red, then blue, most significant bit first. The number of channels is a parameter (8 or 16) and sets the width of `line_out`.
- R5: Every slot lasts CLK_HZ·400 ns clock cycles (100 at 250 MHz). `slot_vld` is a one-cycle pulse in the first cycle of each slot, and `line_out` changes only in such cycles.
- R6: `col_req` is a one-cycle pulse, raised only together with `slot_vld`. It is raised once at the start of the last preamble slot, and once at the start of the first slot of bit 23 of every position except the last. `col_data` is sampled only on the clock edge that ends a `col_req` cycle. A frame makes exactly N requests.
- R7: `busy` rises on the edge that samples `start` in idle and stays high until the last postamble slot ends. `done` is then high for exactly one cycle, the first cycle with `busy` low.
- R8: `start` and `led_count` are ignored while `busy` is high. The running frame keeps its length and data.
- R9: A `led_count` of 0 gives an eight-slot all-zero frame with no requests. Values above MAX_LEDS (default 50) are treated as MAX_LEDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame when idle |
| led_count | input | $clog2(MAX_LEDS+1) | LED positions per channel, sampled with start |
| col_data | input | 24·NUM_CH | Per-channel RGB words, sampled when col_req is high |
| col_req | output | 1 | Colour fetch strobe for the next position |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| slot_vld | output | 1 | First cycle of each output slot |
| line_out | output | NUM_CH | Per-channel LED line levels |

## Verification
When `start` is sampled on an edge, the first slot appears in the next cycle. Slot k begins exactly k·100 cycles later, and `done` appears 100·(8+72N) cycles after that edge. The driver counts clock edges from the start edge to `done` against this figure. The monitor compares `line_out` only in cycles where `slot_vld` is high, against words queued from R3/R4, and it also checks the 100-cycle gap between slots. A colour word is placed on `col_data` in the cycle `col_req` is high and replaced with junk in every other cycle, so a design that samples on the wrong edge sends wrong planes.

// File: rtl/led_enc_pkg.sv
// Shared types and constants for the parallel LED bit-plane encoder.
package led_enc_pkg;
    localparam int BITS_PER_LED  = 24;
    localparam int SLOTS_PER_BIT = 3;
    localparam int PAD_SLOTS     = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_DATA = 2'd2,
        PH_POST = 2'd3
    } phase_t;

    // Reorders an RGB word into the green-red-blue wire order.
    function automatic logic [23:0] rgb_to_grb(input logic [23:0] rgb);
        return {rgb[15:8], rgb[23:16], rgb[7:0]};
    endfunction
endpackage

// File: rtl/led_slot_timer.sv
// Slot prescaler: while run is high, raises tick in the last cycle of
// every TPS-cycle slot. restart realigns the count to a fresh slot.
// Assumes TPS >= 2.
module led_slot_timer #(
    parameter int TPS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CW = $clog2(TPS);
    localparam logic [CW-1:0] LAST = CW'(TPS - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles within the current slot, wrapping at TPS.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/led_frame_seq.sv
// Frame sequencer: walks preamble, per-LED bit/slot positions and
// postamble on each slot tick; issues fetch and load strobes so that the
// next colour is ready before the final bit of a position ends.
module led_frame_seq
    import led_enc_pkg::*;
#(
    parameter int MAX_LEDS = 50,
    parameter int LW       = $clog2(MAX_LEDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] led_count,
    input  logic          tick,
    output phase_t        phase,
    output logic [1:0]    sub,
    output logic [4:0]    bit_idx,
    output logic          accept,
    output logic          load_cur,
    output logic          busy,
    output logic          done,
    output logic          slot_vld,
    output logic          col_req
);
    localparam logic [4:0]    LAST_BIT = 5'(BITS_PER_LED - 1);
    localparam logic [4:0]    PEN_BIT  = 5'(BITS_PER_LED - 2);
    localparam logic [1:0]    LAST_PAD = 2'(PAD_SLOTS - 1);
    localparam logic [1:0]    PEN_PAD  = 2'(PAD_SLOTS - 2);
    localparam logic [1:0]    LAST_SUB = 2'(SLOTS_PER_BIT - 1);
    localparam logic [LW-1:0] MAX_CNT  = LW'(MAX_LEDS);

    phase_t        phase_q;
    logic [1:0]    pad_q, sub_q;
    logic [4:0]    bit_q;
    logic [LW-1:0] led_q, leds_q;
    logic          busy_q, done_q, vld_q, req_q;
    logic          more;
    logic [LW-1:0] clamped;

    // Another LED position follows the current one.
    assign more    = (led_q + LW'(1)) < leds_q;
    // Requested count limited to the supported maximum.
    assign clamped = (led_count > MAX_CNT) ? MAX_CNT : led_count;
    assign accept  = (phase_q == PH_IDLE) && start;

    // Position bookkeeping, advanced once per slot tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            pad_q   <= '0;
            sub_q   <= '0;
            bit_q   <= '0;
            led_q   <= '0;
            leds_q  <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            vld_q   <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            vld_q  <= 1'b0;
            req_q  <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_PRE;
                        pad_q   <= '0;
                        leds_q  <= clamped;
                        led_q   <= '0;
                        busy_q  <= 1'b1;
                        vld_q   <= 1'b1;
                    end
                end
                PH_PRE: begin
                    if (tick) begin
                        vld_q <= 1'b1;
                        if (pad_q == LAST_PAD) begin
                            if (leds_q == '0) begin
                                phase_q <= PH_POST;
                                pad_q   <= '0;
                            end else begin
                                phase_q <= PH_DATA;
                                sub_q   <= '0;
                                bit_q   <= '0;
                            end
                        end else begin
                            pad_q <= pad_q + 1'b1;
                            if (pad_q == PEN_PAD && leds_q != '0) req_q <= 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (tick) begin
                        vld_q <= 1'b1;
                        if (sub_q != LAST_SUB) begin
                            sub_q <= sub_q + 1'b1;
                        end else begin
                            sub_q <= '0;
                            if (bit_q != LAST_BIT) begin
                                bit_q <= bit_q + 1'b1;
                                if (bit_q == PEN_BIT && more) req_q <= 1'b1;
                            end else if (more) begin
                                led_q <= led_q + LW'(1);
                                bit_q <= '0;
                            end else begin
                                phase_q <= PH_POST;
                                pad_q   <= '0;
                            end
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (pad_q == LAST_PAD) begin
                            phase_q <= PH_IDLE;
                            busy_q  <= 1'b0;
                            done_q  <= 1'b1;
                        end else begin
                            vld_q <= 1'b1;
                            pad_q <= pad_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Current colour is replaced on the edge that enters bit 0 of a position.
    assign load_cur = tick && (
        (phase_q == PH_PRE  && pad_q == LAST_PAD && leds_q != '0) ||
        (phase_q == PH_DATA && sub_q == LAST_SUB && bit_q == LAST_BIT && more));

    assign phase    = phase_q;
    assign sub      = sub_q;
    assign bit_idx  = bit_q;
    assign busy     = busy_q;
    assign done     = done_q;
    assign slot_vld = vld_q;
    assign col_req  = req_q;
endmodule

// File: rtl/led_bitplane.sv
// Per-channel colour store and bit-plane output. Each channel holds a
// prefetched word and a word being sent; the output level is decoded from
// the sequencer position. Assumes col_req and load_cur never coincide.
module led_bitplane
    import led_enc_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             col_req,
    input  logic [NUM_CH*BITS_PER_LED-1:0]   col_data,
    input  logic                             load_cur,
    input  phase_t                           phase,
    input  logic [1:0]                       sub,
    input  logic [4:0]                       bit_idx,
    output logic [NUM_CH-1:0]                line_out
);
    localparam logic [4:0] TOP_BIT = 5'(BITS_PER_LED - 1);

    logic [NUM_CH-1:0] plane;
    logic [4:0]        sel;

    assign sel = TOP_BIT - bit_idx;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [BITS_PER_LED-1:0] nxt_q, cur_q;

        // Capture the prefetched word, then promote it at a position boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nxt_q <= '0;
                cur_q <= '0;
            end else begin
                if (col_req)  nxt_q <= rgb_to_grb(col_data[c*BITS_PER_LED +: BITS_PER_LED]);
                if (load_cur) cur_q <= nxt_q;
            end
        end

        assign plane[c] = cur_q[sel];
    end

    // Line level for the current slot: high, data, low, or padding.
    always_comb begin
        line_out = '0;
        if (phase == PH_DATA) begin
            case (sub)
                2'd0:    line_out = '1;
                2'd1:    line_out = plane;
                default: line_out = '0;
            endcase
        end
    end
endmodule

// File: rtl/led_strand_encoder.sv
// Top of the parallel LED bit-plane encoder. Joins the slot prescaler,
// the frame sequencer and the per-channel bit-plane store.
// Assumes CLK_HZ*SLOT_NS gives at least two cycles per slot.
module led_strand_encoder
    import led_enc_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int MAX_LEDS = 50,
    parameter int CLK_HZ   = 250_000_000,
    parameter int SLOT_NS  = 400,
    parameter int LW       = $clog2(MAX_LEDS + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [LW-1:0]                  led_count,
    input  logic [NUM_CH*BITS_PER_LED-1:0] col_data,
    output logic                           col_req,
    output logic                           busy,
    output logic                           done,
    output logic                           slot_vld,
    output logic [NUM_CH-1:0]              line_out
);
    localparam int TPS = int'((64'(CLK_HZ) * 64'(SLOT_NS)) / 64'd1_000_000_000);

    logic       tick, accept, load_cur;
    phase_t     phase;
    logic [1:0] sub;
    logic [4:0] bit_idx;

    led_slot_timer #(.TPS(TPS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (accept),
        .tick    (tick)
    );

    led_frame_seq #(.MAX_LEDS(MAX_LEDS), .LW(LW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .led_count (led_count),
        .tick      (tick),
        .phase     (phase),
        .sub       (sub),
        .bit_idx   (bit_idx),
        .accept    (accept),
        .load_cur  (load_cur),
        .busy      (busy),
        .done      (done),
        .slot_vld  (slot_vld),
        .col_req   (col_req)
    );

    led_bitplane #(.NUM_CH(NUM_CH)) u_plane (
        .clk      (clk),
        .rst_n    (rst_n),
        .col_req  (col_req),
        .col_data (col_data),
        .load_cur (load_cur),
        .phase    (phase),
        .sub      (sub),
        .bit_idx  (bit_idx),
        .line_out (line_out)
    );
endmodule

// File: rtl/led_enc_checker.sv
// Protocol checker for the LED bit-plane encoder, bound to its top.
module led_enc_checker #(
    parameter int NUM_CH = 8,
    parameter int TPS    = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              slot_vld,
    input logic              col_req,
    input logic [NUM_CH-1:0] line_out
);
    logic [31:0] gap_q;
    logic        armed_q;

    // Cycles since the last slot start within the running frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= '0;
            armed_q <= 1'b0;
        end else if (slot_vld) begin
            gap_q   <= '0;
            armed_q <= 1'b1;
        end else if (!busy) begin
            armed_q <= 1'b0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (line_out == '0 && !col_req && !slot_vld));

    assert_line_moves_on_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_out != $past(line_out)) |-> slot_vld);

    assert_slot_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld |=> !slot_vld);

    assert_slot_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld && armed_q) |-> (gap_q == 32'(TPS - 1)));

    assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        col_req |=> !col_req);

    assert_req_on_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        col_req |-> (slot_vld && busy));

    assert_start_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_busy_fall_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind led_strand_encoder led_enc_checker #(.NUM_CH(NUM_CH), .TPS(TPS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .slot_vld (slot_vld),
    .col_req  (col_req),
    .line_out (line_out)
);

// File: tb/led_strand_encoder_bench.sv
module led_strand_encoder_bench;
    localparam int NUM_CH   = 16;
    localparam int MAX_LEDS = 4;
    localparam int LW       = $clog2(MAX_LEDS + 1);
    localparam int TPS      = 100;   // 400 ns at a 4 ns clock
    localparam int DW       = NUM_CH * 24;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [LW-1:0]       led_count = '0;
    logic [DW-1:0]       col_data = '0;
    logic                col_req, busy, done, slot_vld;
    logic [NUM_CH-1:0]   line_out;

    int checks = 0;
    int errors = 0;

    logic [NUM_CH-1:0] exp_q[$];
    int                req_slot_q[$];
    logic [DW-1:0]     pix_mem [0:7];
    int                slot_idx = 0;
    int                req_cnt = 0;
    longint            cyc_all = 0;
    longint            last_vld = 0;
    bit                gap_armed = 1'b0;

    always #2 clk = ~clk;

    led_strand_encoder #(.NUM_CH(NUM_CH), .MAX_LEDS(MAX_LEDS)) u_led_strand_encoder (
        .clk(clk), .rst_n(rst_n), .start(start), .led_count(led_count),
        .col_data(col_data), .col_req(col_req), .busy(busy), .done(done),
        .slot_vld(slot_vld), .line_out(line_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] pix_word(int k, int c, int seed);
        logic [7:0] r, g, b;
        r = 8'(c * 17 + k * 5 + seed);
        g = 8'hF0 ^ 8'(c * 3 + k + seed);
        b = 8'(k * 29 + c * 7 + seed * 3);
        return {r, g, b};
    endfunction

    always @(posedge clk) cyc_all <= cyc_all + 1;

    // Monitor: compares slots, supplies colours, checks request timing.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (slot_vld) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2", "unexpected slot", slot_idx, -1);
                    end else begin
                        logic [NUM_CH-1:0] e;
                        e = exp_q.pop_front();
                        chk(line_out == e, "R3 R4", $sformatf("slot %0d", slot_idx), line_out, e);
                    end
                    if (gap_armed)
                        chk(cyc_all - last_vld == TPS, "R5", "slot spacing", cyc_all - last_vld, TPS);
                    gap_armed = 1'b1;
                    last_vld  = cyc_all;
                end
                if (col_req) begin
                    int es;
                    es = (req_slot_q.size() > 0) ? req_slot_q.pop_front() : -1;
                    chk(slot_vld && (slot_idx == es), "R6", "request slot", slot_idx, es);
                    col_data = pix_mem[req_cnt % 8];
                    req_cnt++;
                end else begin
                    col_data = {(DW/8){8'hA5}};
                end
                if (slot_vld) slot_idx++;
            end
        end
    end

    // Driver: queues the expected frame, starts it, times it to done.
    task automatic run_frame(input int n_req, input int seed, input int poke);
        int     eff, slots;
        longint cyc;
        bit     busy_ok;
        eff   = (n_req > MAX_LEDS) ? MAX_LEDS : n_req;
        slots = 8 + 72 * eff;
        for (int k = 0; k < eff; k++)
            for (int c = 0; c < NUM_CH; c++)
                pix_mem[k][c*24 +: 24] = pix_word(k, c, seed);
        for (int i = 0; i < 4; i++) exp_q.push_back('0);
        for (int k = 0; k < eff; k++) begin
            for (int b = 23; b >= 0; b--) begin
                logic [NUM_CH-1:0] pl;
                for (int c = 0; c < NUM_CH; c++) begin
                    logic [23:0] rgb, grb;
                    rgb = pix_mem[k][c*24 +: 24];
                    grb = {rgb[15:8], rgb[23:16], rgb[7:0]};
                    pl[c] = grb[b];
                end
                exp_q.push_back('1);
                exp_q.push_back(pl);
                exp_q.push_back('0);
            end
        end
        for (int i = 0; i < 4; i++) exp_q.push_back('0);
        if (eff > 0) req_slot_q.push_back(3);
        for (int k = 0; k < eff - 1; k++) req_slot_q.push_back(4 + 72 * k + 69);
        slot_idx  = 0;
        req_cnt   = 0;
        gap_armed = 1'b0;

        @(negedge clk);
        led_count = LW'(n_req);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        busy_ok = 1'b1;
        while (!done && cyc < longint'(slots) * TPS + 20) begin
            if (!busy) busy_ok = 1'b0;
            if (cyc == poke) begin
                start = 1'b1;
                led_count = LW'(1);
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(busy_ok, "R7", "busy held through frame", busy_ok, 1);
        chk(done && cyc == longint'(slots) * TPS, "R7", "cycles start to done", cyc, longint'(slots) * TPS);
        chk(!busy, "R7", "busy low with done", busy, 0);
        chk(exp_q.size() == 0, "R2", "slots left unsent", exp_q.size(), 0);
        chk(req_cnt == eff, "R6", "request count", req_cnt, eff);
        exp_q.delete();
        req_slot_q.delete();
        @(negedge clk);
        chk(!done, "R7", "done width", done, 0);
    endtask

    // Watchdog: a hung run ends as a failure with the summary.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(line_out == '0 && !busy && !done && !slot_vld && !col_req, "R1", "reset outputs",
            {busy, done, slot_vld, col_req}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(line_out == '0 && !busy && !slot_vld && !col_req, "R1", "idle after reset",
            {busy, slot_vld, col_req}, 0);
        run_frame(1, 1, -1);          // R3 R4 single position
        run_frame(2, 40, -1);         // R6 prefetch between positions
        run_frame(0, 0, -1);          // R9 empty frame
        run_frame(7, 90, -1);         // R9 count clamped to MAX_LEDS
        run_frame(2, 200, 3000);      // R8 start and count ignored while busy
        repeat (10) @(negedge clk);
        chk(!busy && line_out == '0, "R8", "no frame from ignored start", busy, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule